// File: doc/BRIEF.md
# Serial Flash Page Write Sequencer

This block sits on the host side of a serial flash (SPI mode 0). It writes a buffer of any length to the flash. The user gives a 24-bit start address, a byte count and a one-cycle start pulse. The block then asks for the data one byte at a time through a request/valid handshake. It cuts the buffer into pieces that never cross a 256-byte page. For every piece it runs three chip-select windows:

1. A write-enable command.
2. A page-program command, followed by the address and the data bytes.
3. A status read that repeats until the write-in-progress bit clears.

A timeout ends a program that never completes and reports an error.

The controller is one state machine with these states: `S_IDLE`, `S_WREN`, `S_GAP_WE`, `S_PROG_OP`, `S_PROG_ADDR`, `S_FETCH`, `S_PROG_DATA`, `S_GAP_PP`, `S_STAT_OP`, `S_STAT_RD`, `S_GAP_ST` and `S_DONE`. Its transitions are:

- **Start.** `S_IDLE` goes to `S_WREN` on start with a non-zero count. With a zero count it goes straight to `S_DONE`.
- **Write enable.** `S_WREN` goes to `S_GAP_WE` when its byte is shifted out. `S_GAP_WE` goes to `S_PROG_OP` when the gap expires.
- **Program command.** `S_PROG_OP` goes to `S_PROG_ADDR` when its byte is shifted out. `S_PROG_ADDR` stays put for the first two address bytes and goes to `S_FETCH` after the third.
- **Data.** `S_FETCH` goes to `S_PROG_DATA` when the user delivers a byte. `S_PROG_DATA` returns to `S_FETCH` while the piece has more bytes. After the last byte of the piece it goes to `S_GAP_PP`.
- **Status poll.** `S_GAP_PP` goes to `S_STAT_OP` when the gap expires. `S_STAT_OP` goes to `S_STAT_RD` when its byte is shifted out. `S_STAT_RD` repeats until a status byte shows bit 0 clear, or the timeout has been reached. It then goes to `S_GAP_ST`.
- **Next step.** `S_GAP_ST` goes to `S_IDLE` after an error. Otherwise it goes to `S_DONE` when no bytes remain, or back to `S_WREN` for the next piece.
- **Finish.** `S_DONE` goes to `S_IDLE` after one cycle.

A serial byte engine inside the block divides the system clock to make the serial clock. A separate piece of combinational logic picks the size of each page piece.

Top module: `spw_flash_writer`

## Requirements
- R1: Every page-program window is preceded by its own chip-select window that carries only the write-enable opcode 0x06.
- R2: A page-program window is one chip-select low period. It carries opcode 0x02 first, then three address bytes (high byte first), then the data bytes. Every byte is sent most significant bit first.
- R3: The first piece holds min(count, 256 − address[7:0]) bytes. Each later piece starts at offset 0 of the next page, with the 24-bit address wrapping. No piece holds more than 256 bytes or crosses a page.
- R4: The serial clock idles low and is low whenever chip select changes. Data out is held constant while the serial clock is high. Chip select rises one system clock after the final serial-clock falling edge, and only after whole bytes.
- R5: After each page-program window there is a status window. It carries opcode 0x05 followed by status bytes in one chip-select low period, and ends only when a status byte has bit 0 = 0. The next page's write enable follows only after that.
- R6: Suppose TIMEOUT_CLKS system clocks have passed since the status window opened and a status byte still shows bit 0 = 1. The window then closes, the block returns to idle and holds err_o high until the next accepted start, and done_o is not pulsed.
- R7: Chip select stays high for at least CS_GAP system clocks between any two windows.
- R8: byte_req_o is high only while the block waits for a data byte, with chip select low. A byte is taken in a cycle where byte_req_o and byte_vld_i are both high. Exactly the requested count is taken.
- R9: After reset, chip select is high, the serial clock is low and all status outputs are low. busy_o is high from the cycle after an accepted start until done_o. done_o is a one-cycle pulse with busy_o low. A zero count pulses done_o in the cycle after start, with no chip-select activity.
- R10: start_i is ignored while busy_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request to begin a write |
| addr_i | input | 24 | Flash start address, sampled with start_i |
| len_i | input | LEN_W | Number of bytes to write, sampled with start_i |
| byte_req_o | output | 1 | Block is waiting for the next data byte |
| byte_vld_i | input | 1 | byte_i holds a valid data byte |
| byte_i | input | 8 | Data byte from the user |
| busy_o | output | 1 | A write is in progress |
| done_o | output | 1 | One-cycle pulse when all pages are programmed |
| err_o | output | 1 | Program timeout seen; held until next start |
| cs_n_o | output | 1 | Flash chip select, active low |
| sck_o | output | 1 | Flash serial clock |
| mosi_o | output | 1 | Serial data to the flash |
| miso_i | input | 1 | Serial data from the flash |

## Verification
The bench builds the block with CLK_DIV = 2, CS_GAP = 3 and TIMEOUT_CLKS = 3000, keeping LEN_W at 16.

- **Divider.** A divider of two runs the counting path of the serial-clock divider, not just the toggle-every-clock case.
- **Gap timer.** A three-clock gap makes the minimum chip-select high time a count the bench can check exactly.
- **Timeout.** The short timeout puts the stuck-busy error path within a few thousand cycles.
- **Page boundaries.** The 16-bit length allows a 300-byte buffer that spans three pages with partial pieces at both ends. Another buffer wraps through the top of the 24-bit address space.

// File: rtl/spw_pkg.sv
package spw_pkg;

    localparam int ADDR_W     = 24;
    localparam int PAGE_BYTES = 256;
    localparam int OFF_W      = $clog2(PAGE_BYTES);
    localparam int CHUNK_W    = OFF_W + 1;

    localparam logic [7:0] OP_WREN = 8'h06;
    localparam logic [7:0] OP_PROG = 8'h02;
    localparam logic [7:0] OP_RDSR = 8'h05;

    typedef enum logic [3:0] {
        S_IDLE,
        S_WREN,
        S_GAP_WE,
        S_PROG_OP,
        S_PROG_ADDR,
        S_FETCH,
        S_PROG_DATA,
        S_GAP_PP,
        S_STAT_OP,
        S_STAT_RD,
        S_GAP_ST,
        S_DONE
    } state_e;

endpackage

// File: rtl/spw_byte_shifter.sv
module spw_byte_shifter #(
    parameter int CLK_DIV = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go_i,
    input  logic [7:0] tx_i,
    input  logic       miso_i,
    output logic       sck_o,
    output logic       mosi_o,
    output logic [7:0] rx_o,
    output logic       done_o
);
    localparam int DIV_W = $clog2(CLK_DIV + 1);

    logic             active;
    logic [DIV_W-1:0] div_q;
    logic [2:0]       bit_q;
    logic [7:0]       tx_q;
    logic [7:0]       rx_q;
    logic             sck_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active <= 1'b0;
            div_q  <= '0;
            bit_q  <= '0;
            tx_q   <= '0;
            rx_q   <= '0;
            sck_q  <= 1'b0;
            done_o <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (go_i && !active) begin
                active <= 1'b1;
                tx_q   <= tx_i;
                div_q  <= '0;
                bit_q  <= '0;
                sck_q  <= 1'b0;
            end else if (active) begin
                if (div_q == DIV_W'(CLK_DIV - 1)) begin
                    div_q <= '0;
                    if (!sck_q) begin
                        sck_q <= 1'b1;
                        rx_q  <= {rx_q[6:0], miso_i};
                    end else begin
                        sck_q <= 1'b0;
                        if (bit_q == 3'd7) begin
                            active <= 1'b0;
                            done_o <= 1'b1;
                        end else begin
                            bit_q <= bit_q + 3'd1;
                            tx_q  <= {tx_q[6:0], 1'b0};
                        end
                    end
                end else begin
                    div_q <= div_q + DIV_W'(1);
                end
            end
        end
    end

    assign sck_o  = sck_q;
    assign mosi_o = tx_q[7];
    assign rx_o   = rx_q;

endmodule

// File: rtl/spw_chunk_calc.sv
module spw_chunk_calc
    import spw_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic [OFF_W-1:0]   page_off_i,
    input  logic [LEN_W-1:0]   remain_i,
    output logic [CHUNK_W-1:0] chunk_o
);
    logic [CHUNK_W-1:0] room;

    always_comb begin
        room = CHUNK_W'(PAGE_BYTES) - CHUNK_W'(page_off_i);
        if (remain_i < LEN_W'(room)) begin
            chunk_o = CHUNK_W'(remain_i);
        end else begin
            chunk_o = room;
        end
    end

endmodule

// File: rtl/spw_flash_writer.sv
module spw_flash_writer
    import spw_pkg::*;
#(
    parameter int LEN_W        = 16,
    parameter int CLK_DIV      = 2,
    parameter int CS_GAP       = 4,
    parameter int TIMEOUT_CLKS = 500000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [LEN_W-1:0]  len_i,
    output logic              byte_req_o,
    input  logic              byte_vld_i,
    input  logic [7:0]        byte_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              err_o,
    output logic              cs_n_o,
    output logic              sck_o,
    output logic              mosi_o,
    input  logic              miso_i
);
    localparam int GAP_W = $clog2(CS_GAP + 1);
    localparam int TMO_W = $clog2(TIMEOUT_CLKS + 1);

    state_e             state, state_n;
    logic               launched, sh_go, sh_done;
    logic [7:0]         sh_tx, sh_rx;
    logic [ADDR_W-1:0]  cur_addr;
    logic [LEN_W-1:0]   remain;
    logic [CHUNK_W-1:0] chunk_left, chunk_len;
    logic [1:0]         addr_idx;
    logic [7:0]         data_byte;
    logic [GAP_W-1:0]   gap_cnt;
    logic [TMO_W-1:0]   tmo_cnt;
    logic               err_r;
    logic               in_send, in_gap, gap_over, tmo_hit;

    assign in_send  = state inside {S_WREN, S_PROG_OP, S_PROG_ADDR, S_PROG_DATA,
                                    S_STAT_OP, S_STAT_RD};
    assign in_gap   = state inside {S_GAP_WE, S_GAP_PP, S_GAP_ST};
    assign gap_over = in_gap && (gap_cnt == GAP_W'(CS_GAP - 1));
    assign tmo_hit  = (tmo_cnt == TMO_W'(TIMEOUT_CLKS));
    assign sh_go    = in_send && !launched;

    spw_byte_shifter #(.CLK_DIV(CLK_DIV)) i_shifter (
        .clk    (clk),
        .rst_n  (rst_n),
        .go_i   (sh_go),
        .tx_i   (sh_tx),
        .miso_i (miso_i),
        .sck_o  (sck_o),
        .mosi_o (mosi_o),
        .rx_o   (sh_rx),
        .done_o (sh_done)
    );

    spw_chunk_calc #(.LEN_W(LEN_W)) i_chunk (
        .page_off_i (cur_addr[OFF_W-1:0]),
        .remain_i   (remain),
        .chunk_o    (chunk_len)
    );

    // next-state decision
    always_comb begin
        state_n = state;
        unique case (state)
            S_IDLE:      if (start_i) state_n = (len_i == '0) ? S_DONE : S_WREN;
            S_WREN:      if (sh_done) state_n = S_GAP_WE;
            S_GAP_WE:    if (gap_over) state_n = S_PROG_OP;
            S_PROG_OP:   if (sh_done) state_n = S_PROG_ADDR;
            S_PROG_ADDR: if (sh_done && addr_idx == 2'd2) state_n = S_FETCH;
            S_FETCH:     if (byte_vld_i) state_n = S_PROG_DATA;
            S_PROG_DATA: if (sh_done) state_n = (chunk_left == CHUNK_W'(1)) ? S_GAP_PP : S_FETCH;
            S_GAP_PP:    if (gap_over) state_n = S_STAT_OP;
            S_STAT_OP:   if (sh_done) state_n = S_STAT_RD;
            S_STAT_RD:   if (sh_done && (!sh_rx[0] || tmo_hit)) state_n = S_GAP_ST;
            S_GAP_ST:    if (gap_over) state_n = err_r ? S_IDLE :
                                                 (remain == '0) ? S_DONE : S_WREN;
            S_DONE:      state_n = S_IDLE;
            default:     state_n = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_n;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            launched   <= 1'b0;
            gap_cnt    <= '0;
            tmo_cnt    <= '0;
            cur_addr   <= '0;
            remain     <= '0;
            chunk_left <= '0;
            addr_idx   <= '0;
            data_byte  <= '0;
            err_r      <= 1'b0;
        end else begin
            if (sh_go)        launched <= 1'b1;
            else if (sh_done) launched <= 1'b0;
            gap_cnt <= in_gap ? gap_cnt + GAP_W'(1) : '0;
            unique case (state)
                S_IDLE: if (start_i) begin
                    cur_addr <= addr_i;
                    remain   <= len_i;
                    err_r    <= 1'b0;
                end
                S_PROG_OP: addr_idx <= '0;
                S_PROG_ADDR: if (sh_done) begin
                    addr_idx   <= addr_idx + 2'd1;
                    chunk_left <= chunk_len;
                end
                S_FETCH: if (byte_vld_i) data_byte <= byte_i;
                S_PROG_DATA: if (sh_done) begin
                    cur_addr   <= cur_addr + ADDR_W'(1);
                    remain     <= remain - LEN_W'(1);
                    chunk_left <= chunk_left - CHUNK_W'(1);
                end
                S_GAP_PP: tmo_cnt <= '0;
                S_STAT_OP: if (!tmo_hit) tmo_cnt <= tmo_cnt + TMO_W'(1);
                S_STAT_RD: begin
                    if (!tmo_hit) tmo_cnt <= tmo_cnt + TMO_W'(1);
                    if (sh_done && sh_rx[0] && tmo_hit) err_r <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    // outputs decoded from state
    always_comb begin
        busy_o     = !(state inside {S_IDLE, S_DONE});
        done_o     = (state == S_DONE);
        err_o      = err_r && (state == S_IDLE);
        byte_req_o = (state == S_FETCH);
        cs_n_o     = !(in_send || state == S_FETCH);
        unique case (state)
            S_WREN:      sh_tx = OP_WREN;
            S_PROG_OP:   sh_tx = OP_PROG;
            S_PROG_ADDR: sh_tx = (addr_idx == 2'd0) ? cur_addr[23:16] :
                                 (addr_idx == 2'd1) ? cur_addr[15:8] : cur_addr[7:0];
            S_PROG_DATA: sh_tx = data_byte;
            S_STAT_OP:   sh_tx = OP_RDSR;
            default:     sh_tx = 8'h00;
        endcase
    end

endmodule

// File: rtl/spw_flash_writer_chk.sv
module spw_flash_writer_chk #(
    parameter int CS_GAP = 4
) (
    input logic clk,
    input logic rst_n,
    input logic cs_n_o,
    input logic sck_o,
    input logic mosi_o,
    input logic byte_req_o,
    input logic busy_o,
    input logic done_o,
    input logic err_o
);
    logic [15:0] hi_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          hi_cnt <= 16'hFFFF;
        else if (!cs_n_o)    hi_cnt <= '0;
        else if (hi_cnt != 16'hFFFF) hi_cnt <= hi_cnt + 16'd1;
    end

    // R4
    sck_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n_o != $past(cs_n_o)) |-> !sck_o);

    // R4
    mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sck_o && $past(sck_o)) |-> $stable(mosi_o));

    // R7
    gap_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n_o) |-> (hi_cnt >= 16'(CS_GAP)));

    // R8
    req_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_req_o |-> (!cs_n_o && !sck_o && busy_o));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o ##1 !done_o);

    // R6
    err_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (!busy_o && !done_o));

endmodule

bind spw_flash_writer spw_flash_writer_chk #(.CS_GAP(CS_GAP)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_n_o     (cs_n_o),
    .sck_o      (sck_o),
    .mosi_o     (mosi_o),
    .byte_req_o (byte_req_o),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .err_o      (err_o)
);

// File: tb/test_spw_flash_writer.sv
module test_spw_flash_writer;
    import spw_pkg::*;

    localparam int CLK_PERIOD   = 10;
    localparam int CLK_DIV      = 2;
    localparam int CS_GAP       = 3;
    localparam int TIMEOUT_CLKS = 3000;
    localparam int LEN_W        = 16;
    localparam int WIP_POLLS    = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [23:0] addr = '0;
    logic [LEN_W-1:0] len = '0;
    logic req, busy, done, err, cs_n, sck, mosi;
    logic vld = 1'b0;
    logic [7:0] din = '0;
    wire  miso;

    always #(CLK_PERIOD/2) clk = ~clk;

    spw_flash_writer #(
        .LEN_W(LEN_W), .CLK_DIV(CLK_DIV), .CS_GAP(CS_GAP), .TIMEOUT_CLKS(TIMEOUT_CLKS)
    ) i_spw_flash_writer (
        .clk(clk), .rst_n(rst_n), .start_i(start), .addr_i(addr), .len_i(len),
        .byte_req_o(req), .byte_vld_i(vld), .byte_i(din),
        .busy_o(busy), .done_o(done), .err_o(err),
        .cs_n_o(cs_n), .sck_o(sck), .mosi_o(mosi), .miso_i(miso)
    );

    typedef struct packed {
        logic [7:0]  op;
        logic [23:0] addr;
        logic [15:0] n;
        logic [15:0] sum;
    } item_t;

    item_t exp_q[$];
    int n_chk = 0, n_bad = 0;
    int plan_idx = 0, host_idx = 0, host_wait = 0;
    int cyc = 0;

    function automatic logic [7:0] pat(input int k);
        return 8'(k * 37 + 11);
    endfunction

    task automatic chk(input bit ok, input string rq, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    // driver side of the scoreboard: expected windows per page piece
    task automatic plan_write(input logic [23:0] a, input int n);
        int left;
        logic [23:0] cur;
        left = n;
        cur  = a;
        while (left > 0) begin
            int room;
            int c;
            logic [15:0] s;
            room = 256 - int'(cur[7:0]);
            c = (left < room) ? left : room;
            s = '0;
            for (int i = 0; i < c; i++) s = s + 16'(pat(plan_idx + i));
            exp_q.push_back('{OP_WREN, 24'h0, 16'h0, 16'h0});
            exp_q.push_back('{OP_PROG, cur, 16'(c), s});
            exp_q.push_back('{OP_RDSR, 24'h0, 16'h0, 16'h0});
            plan_idx += c;
            cur  = cur + 24'(c);
            left -= c;
        end
    endtask

    // user data source
    always @(negedge clk) begin
        if (vld) begin
            vld <= 1'b0;
            host_idx <= host_idx + 1;
        end else if (req) begin
            if (host_wait == 0) begin
                vld <= 1'b1;
                din <= pat(host_idx);
                host_wait <= $urandom_range(0, 2);
            end else begin
                host_wait <= host_wait - 1;
            end
        end
    end

    // flash model and monitor side of the scoreboard
    logic prev_sck = 1'b0, prev_cs = 1'b1;
    int bitn = 0, bytn = 0, fn = 0, hi_cnt = 1000, since_fall = 1000, cs_falls = 0;
    logic [7:0] sh = '0, op = '0;
    logic [23:0] fa = '0;
    logic [15:0] fsum = '0;
    bit wel = 1'b0, stuck = 1'b0;
    int wip_left = 0;

    assign miso = (!cs_n && op == OP_RDSR && bytn >= 1) ? (wip_left != 0) : 1'b0;

    task automatic byte_in(input logic [7:0] b);
        if (bytn == 0) op = b;
        else if (op == OP_PROG) begin
            if (bytn <= 3) fa = {fa[15:0], b};
            else begin fn++; fsum = fsum + 16'(b); end
        end else if (op == OP_RDSR) begin
            if (wip_left > 0 && !stuck) wip_left--;
        end
        bytn++;
    endtask

    task automatic end_window();
        item_t got, e;
        got = '{op, (op == OP_PROG) ? fa : 24'h0, 16'(fn), (op == OP_PROG) ? fsum : 16'h0};
        if (op == OP_WREN) wel = 1'b1;
        if (op == OP_PROG) begin
            chk(wel, "R1", "program without prior write enable", 0, 1);
            wel = 1'b0;
            wip_left = WIP_POLLS;
        end
        if (op == OP_RDSR && !stuck)
            chk(wip_left == 0, "R5", "status window closed while busy", wip_left, 0);
        if (exp_q.size() == 0) begin
            chk(1'b0, "R2", "unexpected window opcode", op, 0);
        end else begin
            e = exp_q.pop_front();
            chk(got.op == e.op, "R2", "window opcode", got.op, e.op);
            chk(got == e, "R3", "address/count of window", {got.addr, got.n}, {e.addr, e.n});
        end
    endtask

    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            since_fall = (!sck && prev_sck) ? 0 : since_fall + 1;
            if (cs_n) begin
                if (!prev_cs) begin
                    chk(bitn == 0, "R4", "chip select rose mid-byte", bitn, 0);
                    chk(since_fall == 1, "R4", "clocks from last sck fall to cs rise", since_fall, 1);
                    end_window();
                end
                hi_cnt++;
            end else begin
                if (prev_cs) begin
                    chk(hi_cnt >= CS_GAP, "R7", "chip select high time", hi_cnt, CS_GAP);
                    cs_falls++;
                    bitn = 0; bytn = 0; op = '0; fn = 0; fsum = '0; fa = '0;
                end
                hi_cnt = 0;
                if (sck && !prev_sck) begin
                    sh = {sh[6:0], mosi};
                    bitn++;
                    if (bitn == 8) begin
                        bitn = 0;
                        byte_in(sh);
                    end
                end
            end
            prev_sck = sck;
            prev_cs  = cs_n;
        end
    end

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    // watchdog
    always @(negedge clk) begin
        if (cyc > 150000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            summary();
        end
    end

    task automatic run(input logic [23:0] a, input int n, input bit expect_err, input bit poke);
        int t;
        int dones;
        int falls0;
        t = 0;
        dones = 0;
        falls0 = cs_falls;
        plan_write(a, n);
        @(negedge clk);
        addr = a; len = LEN_W'(n); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (n == 0) begin
            chk(done == 1'b1, "R9", "zero count done pulse", done, 1);
            chk(busy == 1'b0, "R9", "zero count busy", busy, 0);
        end else begin
            chk(busy == 1'b1, "R9", "busy after start", busy, 1);
            chk(err == 1'b0, "R6", "error cleared by start", err, 0);
        end
        while (t < 60000) begin
            if (done) dones++;
            if ((dones > 0) || err) break;
            @(negedge clk);
            t++;
            // R10: a second start while busy must not disturb the write
            if (poke && t == 50) begin
                addr = 24'hABCDEF; len = LEN_W'(9); start = 1'b1;
            end else begin
                start = 1'b0;
            end
        end
        repeat (6) begin
            @(negedge clk);
            if (done) dones++;
        end
        if (expect_err) begin
            chk(err == 1'b1, "R6", "timeout flag", err, 1);
            chk(busy == 1'b0, "R6", "busy after timeout", busy, 0);
            chk(dones == 0, "R6", "done pulses after timeout", dones, 0);
            chk(t >= TIMEOUT_CLKS, "R6", "cycles before timeout", t, TIMEOUT_CLKS);
        end else begin
            chk(dones == 1, "R9", "done pulse count", dones, 1);
            chk(err == 1'b0, "R6", "no error on good write", err, 0);
        end
        if (n == 0) chk(cs_falls == falls0, "R9", "chip select activity on zero count", cs_falls - falls0, 0);
        if (poke) chk(busy == 1'b0, "R10", "busy after ignored start", busy, 0);
        chk(exp_q.size() == 0, "R5", "windows left unmatched", exp_q.size(), 0);
        chk(host_idx == plan_idx, "R8", "bytes taken from user", host_idx, plan_idx);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cs_n == 1'b1, "R9", "reset chip select", cs_n, 1);
        chk(sck == 1'b0, "R4", "reset serial clock", sck, 0);
        chk(busy == 1'b0, "R9", "reset busy", busy, 0);
        chk(done == 1'b0, "R9", "reset done", done, 0);
        chk(req == 1'b0, "R8", "reset request", req, 0);
        chk(err == 1'b0, "R6", "reset error", err, 0);

        run(24'h0000F0, 300, 1'b0, 1'b0);   // R3: pieces 16, 256, 28
        run(24'h012300, 5, 1'b0, 1'b1);     // R10: start while busy
        run(24'h0001FF, 2, 1'b0, 1'b0);     // R3: one byte each side of a page
        run(24'h000080, 0, 1'b0, 1'b0);     // R9: zero count
        stuck = 1'b1;
        run(24'h003010, 4, 1'b1, 1'b0);     // R6: busy bit never clears
        stuck = 1'b0;
        wip_left = 0;
        run(24'hFFFFFE, 3, 1'b0, 1'b0);     // R3: wrap through top of address space
        summary();
    end

endmodule